// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block turns a fast peripheral clock into the timing skeleton of an I2C controller. A clock-control word carries two fields. The prescale field divides the peripheral clock into an internal clock, which appears as a one-cycle enable `ick_tick`. The gap field lengthens each SCL period in steps of eight internal-clock cycles, on top of a fixed base of twenty. The period is not a plain count. The high half waits for the bus to show SCL high before it counts, so the time SCL takes to rise, and any stretching by a target, add to the period.

A bit engine uses the outputs. `scl_drive_low` asks the open-drain pad to pull SCL low. `sda_change_stb` marks the middle of the low half, where SDA may change. `sda_sample_stb` marks the middle of the high half, where SDA is read. When `enable` is low the counters clear and SCL is released. Both fields are taken from the control word at the start of every period, so a new setting never splits a period.

Top module: `i2c_scl_divider`

## Requirements
- R1: While enabled, `ick_tick` pulses for one clock every (cdf + 1) peripheral clocks, where cdf is the prescale field. The first tick of a period comes (cdf + 1) clocks after the period starts.
- R2: The control word holds cdf in bits [PRESCALE_W-1:0] and the gap field g (0 to 63) in the bits directly above it, [PRESCALE_W+5:PRESCALE_W].
- R3: Each period starts with a low half. In it `scl_drive_low` is 1 for exactly (10 + 4g)·(cdf + 1) clocks, and the half ends on an internal-clock tick.
- R4: In the high half SCL is released. Only ticks that see SCL high through a two-flop synchronizer are counted, and the half ends on the (10 + 4g)-th counted tick. A tick counts only if `scl_in` was sampled high at least two clock edges before it. So, counted from the release, the high half ends after (m0 + 9 + 4g)·(cdf + 1) clocks, with m0 = ceil((S + 3)/(cdf + 1)), where S is the number of extra clocks SCL stays low after the release.
- R5: Exactly one `sda_change_stb` pulse comes in each low half, (5 + 2g)·(cdf + 1) clocks after the low half starts.
- R6: Exactly one `sda_sample_stb` pulse comes in each high half, on the (5 + 2g)-th counted tick, that is (m0 + 4 + 2g)·(cdf + 1) clocks after the release. No sample strobe comes in a low half and no change strobe in a high half.
- R7: A target holding SCL low after the release lengthens the high half as R4 gives. No tick counts toward the high half while SCL is sensed low.
- R8: One clock after `enable` is sampled low, `scl_drive_low`, `ick_tick` and both strobes are 0 and stay 0 while disabled. The next enable starts a complete low half of full length.
- R9: cdf and g are captured when a low half starts, whether after enable or at the end of a high half. A change to the control word during a period takes effect from the next period.
- R10: While reset is asserted all outputs are 0, even with `enable` high.
- R11: Timing holds at the corners: cdf = 0 with g = 0, and the largest cdf (2^PRESCALE_W − 1) with g = 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low clears counters and releases SCL |
| clk_ctrl | input | PRESCALE_W+6 | Control word: gap field above prescale field |
| scl_in | input | 1 | Sensed SCL level from the bus |
| ick_tick | output | 1 | Internal-clock enable, one clock wide |
| scl_drive_low | output | 1 | 1 = pull SCL low |
| sda_change_stb | output | 1 | Mid-low strobe for changing SDA |
| sda_sample_stb | output | 1 | Mid-high strobe for sampling SDA |

## Verification
The hardest case to reach is the alignment of a delayed SCL rise with the free-running internal-clock ticks. Whether the first tick after release counts depends on the synchronizer delay, the stretch length and the prescale ratio, and it matters most at small ratios. The bench models the bus itself. After each release it holds `scl_in` low for a chosen number of clocks, with stretch and prescale ratio drawn at random. It predicts every half length and strobe position from the formulas in the requirements. A control-word write in the middle of a low half, and a disable in the middle of a period, cover the capture and restart rules.

// File: rtl/i2c_sclk_pkg.sv
package i2c_sclk_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PRESCALE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [PRESCALE_W-1:0] div_sel,
  output logic                  tick
);

  logic [PRESCALE_W-1:0] pre_cnt_q;
  logic [PRESCALE_W-1:0] pre_cnt_d;

  // tick when the count reaches the divisor; >= keeps it from running away
  always_comb begin
    tick      = run && (pre_cnt_q >= div_sel);
    pre_cnt_d = pre_cnt_q + 1'b1;
    if (!run || tick) begin
      pre_cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q <= '0;
    end else begin
      pre_cnt_q <= pre_cnt_d;
    end
  end

endmodule

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ff_q[0] <= 1'b0;
        end else begin
          ff_q[0] <= d;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ff_q[s] <= 1'b0;
        end else begin
          ff_q[s] <= ff_q[s-1];
        end
      end
    end
  end

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import i2c_sclk_pkg::*;
#(
  parameter int PRESCALE_W = 3,
  parameter int GAP_W      = 6,
  parameter int BASE_CYC   = 20,
  parameter int GAP_STEP   = 8,
  localparam int CTRL_W    = PRESCALE_W + GAP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [CTRL_W-1:0]     ctrl,
  input  logic                  tick,
  input  logic                  scl_hi,
  output logic                  run,
  output logic [PRESCALE_W-1:0] cdf_q,
  output logic                  drive_low,
  output logic                  change_stb,
  output logic                  sample_stb
);

  localparam int HALF_BASE = BASE_CYC / 2;
  localparam int HALF_STEP = GAP_STEP / 2;
  localparam int MAX_HALF  = HALF_BASE + HALF_STEP * ((1 << GAP_W) - 1);
  localparam int CNT_W     = $clog2(MAX_HALF + 1);

  scl_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] gap_q;
  logic             cfg_load;
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] mid_idx;
  logic             at_last;
  logic             at_mid;

  // each half of the period: base/2 + step/2 per gap unit, in internal ticks
  always_comb begin
    half_len = CNT_W'(HALF_BASE) + CNT_W'(HALF_STEP) * CNT_W'(gap_q);
    mid_idx  = (half_len >> 1) - 1'b1;
    at_last  = (cnt_q == half_len - 1'b1);
    at_mid   = (cnt_q == mid_idx);
  end

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    cfg_load   = 1'b0;
    change_stb = 1'b0;
    sample_stb = 1'b0;
    if (!enable) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d  = PH_LOW;
          cnt_d    = '0;
          cfg_load = 1'b1;
        end
        PH_LOW: begin
          if (tick) begin
            change_stb = at_mid;
            if (at_last) begin
              phase_d = PH_HIGH;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_HIGH: begin
          // hold the count while SCL is sensed low: rise time and stretching
          if (tick && scl_hi) begin
            sample_stb = at_mid;
            if (at_last) begin
              phase_d  = PH_LOW;
              cnt_d    = '0;
              cfg_load = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      gap_q   <= '0;
      cdf_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (cfg_load) begin
        gap_q <= ctrl[CTRL_W-1:PRESCALE_W];
        cdf_q <= ctrl[PRESCALE_W-1:0];
      end
    end
  end

  assign run       = (phase_q != PH_IDLE);
  assign drive_low = (phase_q == PH_LOW);

  // R1: a nonzero divisor never gives back-to-back ticks within one setting
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (cdf_q != '0) && !cfg_load |=> !tick);

  // R3: the low half only ends on an internal-clock tick
  p_low_end_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH) && $past(phase_q == PH_LOW) |-> $past(tick) && $past(enable));

  // R4: the high half only ends on a tick that saw SCL high
  p_high_end_scl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) && $past(phase_q == PH_HIGH) |-> $past(tick) && $past(scl_hi));

  // R9: captured settings do not move inside a half
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) && (phase_q == $past(phase_q)) |-> $stable(gap_q) && $stable(cdf_q));

endmodule

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider #(
  parameter int PRESCALE_W  = 3,
  parameter int GAP_W       = 6,
  parameter int BASE_CYC    = 20,
  parameter int GAP_STEP    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_W     = PRESCALE_W + GAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CTRL_W-1:0] clk_ctrl,
  input  logic              scl_in,
  output logic              ick_tick,
  output logic              scl_drive_low,
  output logic              sda_change_stb,
  output logic              sda_sample_stb
);

  logic                  run;
  logic                  tick;
  logic                  scl_hi;
  logic [PRESCALE_W-1:0] cdf_q;

  scl_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scl_in),
    .q     (scl_hi)
  );

  scl_prescaler #(
    .PRESCALE_W (PRESCALE_W)
  ) u_prescaler (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .div_sel (cdf_q),
    .tick    (tick)
  );

  scl_phase_fsm #(
    .PRESCALE_W (PRESCALE_W),
    .GAP_W      (GAP_W),
    .BASE_CYC   (BASE_CYC),
    .GAP_STEP   (GAP_STEP)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .ctrl       (clk_ctrl),
    .tick       (tick),
    .scl_hi     (scl_hi),
    .run        (run),
    .cdf_q      (cdf_q),
    .drive_low  (scl_drive_low),
    .change_stb (sda_change_stb),
    .sample_stb (sda_sample_stb)
  );

  assign ick_tick = tick;

  // R8: one clock after disable the pad is released and the tick stops
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_drive_low && !ick_tick);

endmodule

// File: tb/test_i2c_scl_divider.sv
module test_i2c_scl_divider;

  localparam int PW = 3;
  localparam int GW = 6;
  localparam int CW = PW + GW;
  localparam int LIMIT = 20000;

  logic          clk;
  logic          rst_n;
  logic          enable;
  logic [CW-1:0] clk_ctrl;
  logic          scl_in;
  logic          ick_tick;
  logic          scl_drive_low;
  logic          sda_change_stb;
  logic          sda_sample_stb;

  int n_chk;
  int n_fail;
  bit done;

  i2c_scl_divider #(.PRESCALE_W(PW), .GAP_W(GW)) i_i2c_scl_divider (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .clk_ctrl       (clk_ctrl),
    .scl_in         (scl_in),
    .ick_tick       (ick_tick),
    .scl_drive_low  (scl_drive_low),
    .sda_change_stb (sda_change_stb),
    .sda_sample_stb (sda_sample_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [CW-1:0] pack(input int cdf, input int gap);
    return {GW'(gap), PW'(cdf)};
  endfunction

  function automatic int half_ticks(input int gap);
    return 10 + 4 * gap;
  endfunction

  function automatic int first_counted(input int s, input int p);
    int m;
    m = (s + 3 + p - 1) / p;
    if (m < 1) m = 1;
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at the negedge where scl_drive_low was first seen 1
  task automatic run_period(input string ctx, input int cdf, input int gap, input int s,
                            input bit mid_chg, input logic [CW-1:0] new_ctrl);
    int p, l, m, m0;
    int k, tick_err, chg_n, chg_pos, smp_stray;
    int j, h_tick_err, smp_n, smp_pos, chg_stray;
    p = cdf + 1;
    l = half_ticks(gap);
    m = l / 2;
    m0 = first_counted(s, p);
    k = 0; tick_err = 0; chg_n = 0; chg_pos = -1; smp_stray = 0;
    scl_in = 1'b0;
    while (scl_drive_low && k < LIMIT) begin
      if (ick_tick != (((k + 1) % p) == 0)) tick_err++;
      if (sda_change_stb) begin chg_n++; chg_pos = k + 1; end
      if (sda_sample_stb) smp_stray++;
      if (mid_chg && k == 1) clk_ctrl = new_ctrl;
      @(negedge clk);
      k++;
    end
    check(k == l * p, {ctx, " R3/R2 low half length"}, k, l * p);
    check(tick_err == 0, {ctx, " R1 tick spacing in low half"}, tick_err, 0);
    check(chg_n == 1 && chg_pos == m * p, {ctx, " R5 change strobe position"}, chg_pos, m * p);
    j = 0; h_tick_err = 0; smp_n = 0; smp_pos = -1; chg_stray = 0;
    while (!scl_drive_low && j < LIMIT) begin
      scl_in = (j >= s);
      if (ick_tick != (((j + 1) % p) == 0)) h_tick_err++;
      if (sda_sample_stb) begin smp_n++; smp_pos = j + 1; end
      if (sda_change_stb) chg_stray++;
      @(negedge clk);
      j++;
    end
    check(j == (m0 + l - 1) * p, {ctx, " R4/R7 high half length"}, j, (m0 + l - 1) * p);
    check(h_tick_err == 0, {ctx, " R1 tick spacing in high half"}, h_tick_err, 0);
    check(smp_n == 1 && smp_pos == (m0 + m - 1) * p, {ctx, " R6 sample strobe position"},
          smp_pos, (m0 + m - 1) * p);
    check(smp_stray == 0 && chg_stray == 0, {ctx, " R6 strobe in wrong half"},
          smp_stray + chg_stray, 0);
  endtask

  task automatic start(input int cdf, input int gap);
    enable = 1'b0;
    @(negedge clk);
    clk_ctrl = pack(cdf, gap);
    enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int quiet_err;
    void'($urandom(32'h1C2D5EED));
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; enable = 1'b1; clk_ctrl = pack(0, 0); scl_in = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset holds every output low even with enable high
    check(!scl_drive_low && !ick_tick && !sda_change_stb && !sda_sample_stb,
          "R10 outputs during reset", {scl_drive_low, ick_tick, sda_change_stb, sda_sample_stb}, 0);
    enable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 corner: fastest setting
    start(0, 0);
    run_period("R11 cdf0 gap0", 0, 0, 0, 1'b0, '0);
    run_period("R11 cdf0 gap0 again", 0, 0, 0, 1'b0, '0);
    // R7: long stretch at the fastest ratio
    run_period("R7 stretch 20", 0, 0, 20, 1'b0, '0);

    // R9: write the control word mid-low; new values only from the next period
    start(1, 2);
    run_period("R9 old setting", 1, 2, 0, 1'b1, pack(2, 5));
    run_period("R9 new setting", 2, 5, 1, 1'b0, '0);

    // R8: disable in the middle of a low half
    start(3, 1);
    repeat (7) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    quiet_err = 0;
    for (int i = 0; i < 30; i++) begin
      if (scl_drive_low || ick_tick || sda_change_stb || sda_sample_stb) quiet_err++;
      @(negedge clk);
    end
    check(quiet_err == 0, "R8 quiet while disabled", quiet_err, 0);
    clk_ctrl = pack(3, 1);
    enable = 1'b1;
    @(negedge clk);
    run_period("R8 restart full period", 3, 1, 2, 1'b0, '0);

    // R11 corner: largest divisor and gap
    start(7, 63);
    run_period("R11 cdf7 gap63", 7, 63, 5, 1'b0, '0);

    // constrained random settings and stretches
    for (int it = 0; it < 16; it++) begin
      int c, g, s1, s2;
      c  = $urandom % 8;
      g  = $urandom % 12;
      s1 = $urandom % 6;
      s2 = $urandom % 12;
      start(c, g);
      run_period("R4 random a", c, g, s1, 1'b0, '0);
      run_period("R7 random b", c, g, s2, 1'b0, '0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule